// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface

This block is the command front end of a 16-bit parallel NOR flash. A host drives a word address, write data and three active-high strobes: output enable, write enable and chip select. The block samples them on every rising edge of a system clock. A command is accepted on the sample where write enable first rises while chip select is high and output enable is low. Only the low byte of the write data is decoded, and it selects what later reads return: words from the array, the device status, or the identifier codes. The array itself lives outside the block. The block presents the even byte address of the word being read and takes back the even and odd bytes.

The live status comes from the program and erase engine, which is outside this block. The block does not return it directly. It keeps a snapshot that is refreshed whenever output enable or chip select rises, and status reads return that snapshot. Command bytes for program setup and erase setup put the block into holding modes. In those modes reads return zero and further command writes are not decoded. Only a reset leaves them.

The block has no data stream, so it has no valid/ready handshake. Every pin is a plain level sampled once per clock. Read data is registered: it shows the result of the strobes sampled at one clock edge from that edge until the next.

Top module: `flash_ci`

## Requirements
- R1: After reset the mode is read array, and the status snapshot, the previous-strobe register and the read data are all zero.
- R2: The strobes are encoded as a control value with output enable at bit 0, write enable at bit 1 and chip select at bit 2. A read is served only when this value is 5 (output enable and chip select high, write enable low). The read data registered at a clock edge is zero for any other control value sampled at that edge.
- R3: A command is accepted only when the control value is 6 (write enable and chip select high, output enable low) and write enable was low on the previous sample. Holding write enable high for further samples, or asserting it with another control value, leaves the mode unchanged.
- R4: Only bits 7:0 of the write data are decoded as a command. Bits 15:8 have no effect on the mode.
- R5: In a read mode (array, status, identifier), command 0x90 enters identifier mode and 0x70 enters status mode.
- R6: In a read mode, command 0x40 or 0x10 enters program setup and 0x20 enters erase setup. In either setup mode, reads return 0x0000 and command writes leave the mode unchanged.
- R7: In a read mode, commands 0xFF, 0xD0 and 0xB0, and every byte not listed in R5 or R6, select read array.
- R8: In array mode, reading word address A drives byte address 2A on the memory port. The returned word has the even byte (at 2A) in bits 15:8 and the odd byte (at 2A+1) in bits 7:0.
- R9: In identifier mode, word address 0 reads 0x8893, word address 1 reads 0x0089, and every other address reads 0x0000.
- R10: In status mode, a read returns the 8-bit status snapshot zero-extended to 16 bits. The snapshot copies the live status at each sample where output enable or chip select is high after being low on the previous sample. A read taken at that same sample returns the snapshot as it stood before the copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 19 | Word address |
| bus_wdata | input | 16 | Write data; the low byte carries the command |
| bus_oe | input | 1 | Output enable, active high |
| bus_we | input | 1 | Write enable, active high |
| bus_cs | input | 1 | Chip select, active high |
| dev_status | input | 8 | Live status from the program/erase engine |
| bus_rdata | output | 16 | Registered read data |
| mem_addr | output | 20 | Even byte address of the addressed word |
| mem_even | input | 8 | Array byte at mem_addr |
| mem_odd | input | 8 | Array byte at mem_addr + 1 |

## Verification
A status read and a status snapshot refresh can happen on the same sample. This occurs whenever a read starts with output enable or chip select rising from low. The bench provokes it in three ways: with both strobes rising from idle, with only chip select rising while output enable stays high, and with the live status changed just before the rising sample. It judges the result by requiring that the read returns the previous snapshot and that the next held read returns the new status. The bench also separates a write-enable edge from a held write enable, so that a command is not taken twice.

// File: rtl/flash_ci_pkg.sv
package flash_ci_pkg;

  typedef enum logic [2:0] {
    MODE_ARRAY     = 3'd0,
    MODE_STATUS    = 3'd1,
    MODE_IDENT     = 3'd2,
    MODE_PGM_SETUP = 3'd3,
    MODE_ERS_SETUP = 3'd4
  } fci_mode_e;

  localparam logic [7:0] CMD_PGM_A   = 8'h40;
  localparam logic [7:0] CMD_PGM_B   = 8'h10;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;

  function automatic logic is_setup(fci_mode_e m);
    return (m == MODE_PGM_SETUP) || (m == MODE_ERS_SETUP);
  endfunction

endpackage

// File: rtl/flash_ci_strobe.sv
module flash_ci_strobe #(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oe,
  input  logic              we,
  input  logic              cs,
  input  logic [STAT_W-1:0] dev_status,
  output logic              rd_req,
  output logic              cmd_stb,
  output logic [STAT_W-1:0] stat_buf
);

  logic prev_oe, prev_we, prev_cs;
  logic snap_en;

  // previous-sample strobe levels
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_oe <= 1'b0;
      prev_we <= 1'b0;
      prev_cs <= 1'b0;
    end else begin
      prev_oe <= oe;
      prev_we <= we;
      prev_cs <= cs;
    end
  end

  assign rd_req  = oe && cs && !we;
  assign cmd_stb = we && cs && !oe && !prev_we;
  assign snap_en = (oe && !prev_oe) || (cs && !prev_cs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_buf <= '0;
    else if (snap_en) stat_buf <= dev_status;
  end

  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb); // R3

  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && prev_oe && prev_cs) |=> $stable(stat_buf)); // R10

endmodule

// File: rtl/flash_ci_cmd.sv
module flash_ci_cmd
  import flash_ci_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_stb,
  input  logic [CMD_W-1:0] cmd_byte,
  output fci_mode_e        mode
);

  fci_mode_e mode_nxt;

  always_comb begin
    mode_nxt = mode;
    if (cmd_stb && !is_setup(mode)) begin
      case (8'(cmd_byte))
        CMD_PGM_A, CMD_PGM_B: mode_nxt = MODE_PGM_SETUP;
        CMD_ERASE:            mode_nxt = MODE_ERS_SETUP;
        CMD_STATUS:           mode_nxt = MODE_STATUS;
        CMD_IDENT:            mode_nxt = MODE_IDENT;
        default:              mode_nxt = MODE_ARRAY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= MODE_ARRAY;
    else        mode <= mode_nxt;
  end

  AST_NO_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_stb |=> $stable(mode)); // R3

  AST_SETUP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    is_setup(mode) |=> mode == $past(mode)); // R6

  AST_IDENT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && !is_setup(mode) && 8'(cmd_byte) == CMD_IDENT) |=> mode == MODE_IDENT); // R5

  AST_CONFIRM_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && !is_setup(mode) && 8'(cmd_byte) == CMD_CONFIRM) |=> mode == MODE_ARRAY); // R7

endmodule

// File: rtl/flash_ci_rdmux.sv
module flash_ci_rdmux
  import flash_ci_pkg::*;
#(
  parameter int          ADDR_W   = 19,
  parameter int          DATA_W   = 16,
  parameter int          STAT_W   = 8,
  parameter logic [15:0] DEV_CODE = 16'h8893,
  parameter logic [15:0] MFR_CODE = 16'h0089
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  fci_mode_e         mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W/2-1:0] mem_even,
  input  logic [DATA_W/2-1:0] mem_odd,
  input  logic [STAT_W-1:0] stat_buf,
  output logic [DATA_W-1:0] rdata
);

  localparam int PAD_W = DATA_W - STAT_W;

  logic [DATA_W-1:0] sel_word;
  logic [DATA_W-1:0] id_word;

  always_comb begin
    if (addr == ADDR_W'(0))      id_word = DATA_W'(DEV_CODE);
    else if (addr == ADDR_W'(1)) id_word = DATA_W'(MFR_CODE);
    else                         id_word = '0;
  end

  always_comb begin
    case (mode)
      MODE_ARRAY:  sel_word = {mem_even, mem_odd};
      MODE_STATUS: sel_word = {{PAD_W{1'b0}}, stat_buf};
      MODE_IDENT:  sel_word = id_word;
      default:     sel_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_req) rdata <= sel_word;
    else             rdata <= '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> rdata == '0); // R1

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> rdata == '0); // R2

  AST_SETUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && is_setup(mode)) |=> rdata == '0); // R6

  AST_MFR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && mode == MODE_IDENT && addr == ADDR_W'(1)) |=> rdata == DATA_W'(MFR_CODE)); // R9

endmodule

// File: rtl/flash_ci.sv
module flash_ci
  import flash_ci_pkg::*;
#(
  parameter int          ADDR_W   = 19,
  parameter int          DATA_W   = 16,
  parameter int          STAT_W   = 8,
  parameter logic [15:0] DEV_CODE = 16'h8893,
  parameter logic [15:0] MFR_CODE = 16'h0089
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_oe,
  input  logic                bus_we,
  input  logic                bus_cs,
  input  logic [STAT_W-1:0]   dev_status,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [ADDR_W:0]     mem_addr,
  input  logic [DATA_W/2-1:0] mem_even,
  input  logic [DATA_W/2-1:0] mem_odd
);

  localparam int CMD_W = DATA_W / 2;

  logic              rd_req;
  logic              cmd_stb;
  logic [STAT_W-1:0] stat_buf;
  fci_mode_e         mode;

  assign mem_addr = {bus_addr, 1'b0};

  flash_ci_strobe #(.STAT_W(STAT_W)) u_strobe (
    .clk(clk), .rst_n(rst_n),
    .oe(bus_oe), .we(bus_we), .cs(bus_cs),
    .dev_status(dev_status),
    .rd_req(rd_req), .cmd_stb(cmd_stb), .stat_buf(stat_buf)
  );

  flash_ci_cmd #(.CMD_W(CMD_W)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .cmd_stb(cmd_stb), .cmd_byte(bus_wdata[CMD_W-1:0]),
    .mode(mode)
  );

  flash_ci_rdmux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W),
    .DEV_CODE(DEV_CODE), .MFR_CODE(MFR_CODE)
  ) u_rdmux (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .mode(mode), .addr(bus_addr),
    .mem_even(mem_even), .mem_odd(mem_odd),
    .stat_buf(stat_buf), .rdata(bus_rdata)
  );

  AST_HIGH_BYTE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && !is_setup(mode) && bus_wdata[CMD_W-1:0] == CMD_W'(8'hFF)
     && bus_wdata[DATA_W-1:CMD_W] != '0) |=> mode == MODE_ARRAY); // R4

endmodule

// File: tb/sim_flash_ci.sv
`timescale 1ns/1ps
module sim_flash_ci;

  localparam int NV = 29;
  // row layout: {ctl[2:0], addr[7:0], wdata[15:0], status[7:0], expect[15:0], req[3:0]}
  // ctl bits: OE=bit0, WE=bit1, CS=bit2; 5 = read, 6 = write
  localparam logic [54:0] VEC [NV] = '{
    {3'd0, 8'd0,   16'h0000, 8'h00, 16'h0000, 4'd2},  // R2 idle
    {3'd5, 8'd2,   16'h0000, 8'h00, 16'h1F26, 4'd8},  // R8 array word
    {3'd5, 8'd100, 16'h0000, 8'h00, 16'hFFFF, 4'd8},  // R8 erased word
    {3'd0, 8'd0,   16'h0000, 8'h00, 16'h0000, 4'd2},
    {3'd6, 8'd0,   16'h0090, 8'h00, 16'h0000, 4'd5},  // R5 identifier
    {3'd0, 8'd0,   16'h0000, 8'h00, 16'h0000, 4'd2},
    {3'd5, 8'd0,   16'h0000, 8'h00, 16'h8893, 4'd9},  // R9 device code
    {3'd5, 8'd1,   16'h0000, 8'h00, 16'h0089, 4'd9},  // R9 maker code
    {3'd5, 8'd2,   16'h0000, 8'h00, 16'h0000, 4'd9},  // R9 other address
    {3'd6, 8'd0,   16'h70FF, 8'h00, 16'h0000, 4'd4},  // R4 high byte ignored
    {3'd0, 8'd0,   16'h0000, 8'h00, 16'h0000, 4'd2},
    {3'd5, 8'd7,   16'h0000, 8'h00, 16'h656C, 4'd4},  // R4 back in array
    {3'd6, 8'd0,   16'h0070, 8'h80, 16'h0000, 4'd5},  // R5 status
    {3'd6, 8'd0,   16'h00FF, 8'h80, 16'h0000, 4'd3},  // R3 held WE ignored
    {3'd0, 8'd0,   16'h0000, 8'h80, 16'h0000, 4'd2},
    {3'd5, 8'd0,   16'h0000, 8'h80, 16'h0000, 4'd10}, // R10 old snapshot
    {3'd5, 8'd0,   16'h0000, 8'h81, 16'h0080, 4'd10}, // R10 new snapshot
    {3'd0, 8'd0,   16'h0000, 8'h81, 16'h0000, 4'd2},
    {3'd5, 8'd0,   16'h0000, 8'h81, 16'h0080, 4'd10}, // R10 same-cycle
    {3'd1, 8'd0,   16'h0000, 8'h42, 16'h0000, 4'd2},  // R2 OE only
    {3'd5, 8'd0,   16'h0000, 8'h42, 16'h0081, 4'd10}, // R10 CS-only rise
    {3'd5, 8'd0,   16'h0000, 8'h00, 16'h0042, 4'd10},
    {3'd0, 8'd0,   16'h0000, 8'h00, 16'h0000, 4'd2},
    {3'd6, 8'd0,   16'h0040, 8'h00, 16'h0000, 4'd6},  // R6 program setup
    {3'd0, 8'd0,   16'h0000, 8'h00, 16'h0000, 4'd2},
    {3'd5, 8'd2,   16'h0000, 8'h00, 16'h0000, 4'd6},  // R6 read zero
    {3'd6, 8'd0,   16'h00FF, 8'h00, 16'h0000, 4'd6},  // R6 write ignored
    {3'd0, 8'd0,   16'h0000, 8'h00, 16'h0000, 4'd2},
    {3'd5, 8'd2,   16'h0000, 8'h00, 16'h0000, 4'd6}   // R6 still setup
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_oe = 1'b0, bus_we = 1'b0, bus_cs = 1'b0;
  logic [7:0]  dev_status = '0;
  logic [15:0] bus_rdata;
  logic [19:0] mem_addr;
  logic [7:0]  mem_even, mem_odd;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [7:0] byte_at(logic [19:0] b);
    if (b < 20'd16) return 8'(b * 7 + 3);
    return 8'hFF;
  endfunction

  always_comb begin
    mem_even = byte_at(mem_addr);
    mem_odd  = byte_at(mem_addr + 20'd1);
  end

  flash_ci u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_oe(bus_oe), .bus_we(bus_we), .bus_cs(bus_cs), .dev_status(dev_status),
    .bus_rdata(bus_rdata), .mem_addr(mem_addr), .mem_even(mem_even), .mem_odd(mem_odd)
  );

  task automatic check(input logic [15:0] exp, input string req);
    n_run++;
    if (bus_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata=%04h expected=%04h", req, bus_rdata, exp);
    end
  endtask

  task automatic step(input logic [2:0] ctl, input logic [18:0] a, input logic [15:0] wd,
                      input logic [7:0] st, input logic [15:0] exp, input string req);
    @(negedge clk);
    {bus_cs, bus_we, bus_oe} = ctl;
    bus_addr = a; bus_wdata = wd; dev_status = st;
    @(posedge clk);
    #1;
    check(exp, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    {bus_cs, bus_we, bus_oe} = 3'b000;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check(16'h0000, "R1 rdata in reset");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [54:0] v;
      v = VEC[i];
      step(v[54:52], 19'(v[51:44]), v[43:28], v[27:20], v[19:4],
           $sformatf("R%0d row %0d", v[3:0], i));
    end

    // R1: reset clears read data and returns to array mode
    step(3'd0, 0, 0, 0, 16'h0000, "R2");
    step(3'd5, 2, 0, 0, 16'h0000, "R6 before reset");
    do_reset();
    #1 check(16'h0000, "R1 rdata after reset");
    step(3'd5, 2, 0, 0, 16'h1F26, "R1 array mode after reset");

    // R10 status snapshot
    step(3'd6, 0, 16'h0070, 8'h00, 16'h0000, "R5");
    step(3'd0, 0, 0, 8'h33, 16'h0000, "R2");
    step(3'd5, 0, 0, 8'h33, 16'h0000, "R10 pre-copy value");
    step(3'd5, 0, 0, 8'h55, 16'h0033, "R10 copied value");

    // R7 confirm and resume codes
    step(3'd6, 0, 16'h00D0, 0, 16'h0000, "R7");
    step(3'd0, 0, 0, 0, 16'h0000, "R2");
    step(3'd5, 2, 0, 0, 16'h1F26, "R7 0xD0 to array");
    step(3'd6, 0, 16'h0090, 0, 16'h0000, "R5");
    step(3'd0, 0, 0, 0, 16'h0000, "R2");
    step(3'd6, 0, 16'h00B0, 0, 16'h0000, "R7");
    step(3'd0, 0, 0, 0, 16'h0000, "R2");
    step(3'd5, 7, 0, 0, 16'h656C, "R7 0xB0 to array");

    // R6 erase setup is sticky
    step(3'd6, 0, 16'h0020, 0, 16'h0000, "R6");
    step(3'd0, 0, 0, 0, 16'h0000, "R2");
    step(3'd5, 2, 0, 0, 16'h0000, "R6 erase setup read");
    step(3'd6, 0, 16'h0070, 0, 16'h0000, "R6");
    step(3'd0, 0, 0, 0, 16'h0000, "R2");
    step(3'd5, 2, 0, 0, 16'h0000, "R6 erase setup ignores write");

    // R6 alternate program code
    do_reset();
    step(3'd6, 0, 16'h0010, 0, 16'h0000, "R6");
    step(3'd0, 0, 0, 0, 16'h0000, "R2");
    step(3'd5, 2, 0, 0, 16'h0000, "R6 0x10 program setup");

    // R7 unknown byte from identifier mode
    do_reset();
    step(3'd6, 0, 16'h0090, 0, 16'h0000, "R5");
    step(3'd0, 0, 0, 0, 16'h0000, "R2");
    step(3'd6, 0, 16'h0055, 0, 16'h0000, "R7");
    step(3'd0, 0, 0, 0, 16'h0000, "R2");
    step(3'd5, 0, 0, 0, 16'h030A, "R7 unknown byte to array");

    // R2 non-read control values
    step(3'd7, 2, 0, 0, 16'h0000, "R2 ctl 7");
    step(3'd4, 2, 0, 0, 16'h0000, "R2 ctl 4");
    step(3'd1, 2, 0, 0, 16'h0000, "R2 ctl 1");

    // R3 writes without the accepted control value
    step(3'd2, 0, 16'h0070, 0, 16'h0000, "R3");
    step(3'd0, 0, 0, 0, 16'h0000, "R2");
    step(3'd5, 2, 0, 0, 16'h1F26, "R3 WE without CS ignored");
    step(3'd0, 0, 0, 0, 16'h0000, "R2");
    step(3'd7, 0, 16'h0090, 0, 16'h0000, "R3");
    step(3'd0, 0, 0, 0, 16'h0000, "R2");
    step(3'd5, 0, 0, 0, 16'h030A, "R3 WE with OE ignored");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule